// File: doc/BRIEF.md
# Rotating Per-Bank Refresh Scheduler

This block issues refresh operations to the banks of one memory channel, one bank at a time, in a fixed rotating order. A countdown timer divides the channel's full refresh period evenly across all banks. Each time the timer expires, one more refresh becomes owed. The owed refresh is always aimed at the bank under a rotating pointer. It goes out only when that bank is idle, the shared command/data bus is idle, and the bank's rank still has room in its activate window.

The block also holds the shared occupancy state that a refresh must respect. This is one busy countdown per bank, a set of bus countdowns (plain occupancy, read-to-write turnaround and read rank switch), and a sliding activate window per rank. The channel's access scheduler reports each access it launches on the access inputs, so that accesses and refreshes occupy the same resources. A refresh is weighed before any access in the same cycle. If the two coincide, the access report is dropped. A refresh occupies the bus exactly as an access does. If owed refreshes pile up to the ceiling, a sticky error output rises.

Top module: `refresh_rotator`

## Requirements
- R1: While reset is held, and in the first cycle after release, `ref_pending` is 0, `ref_bank` is 0, `ref_overflow` is 0, `ref_fire` is 0 and every bit of `bank_free` is 1.
- R2: The refresh interval is `REFRESH_PERIOD / (NUM_RANKS*BANKS_PER_RANK)` enabled cycles. The first enabled cycle after reset adds one owed refresh. After that, one is added every interval, in enabled cycles only.
- R3: `ref_fire` is high in a cycle exactly when all of these hold: `ref_enable` is 1, `ref_pending` is nonzero, `bank_free[ref_bank]` is 1, `bus_free` is 1, and `act_ok` of the target rank is 1. Each firing lowers the owed count by one.
- R4: A firing advances `ref_bank` by one on the next cycle, and bank `NUM_BANKS-1` wraps to bank 0. Bank index b belongs to rank b / BANKS_PER_RANK.
- R5: A refresh or access launched in cycle c makes its bank not free in cycles c+1 through c+BANK_BUSY-1. The bank is free again in cycle c+BANK_BUSY.
- R6: A refresh or a write launched in cycle c clears `bus_free` and `wr_ok` until cycle c+BUS_BUSY. A refresh does not change which rank last drove data.
- R7: A read launched in cycle c keeps `wr_ok` low until cycle c+BUS_BUSY+RD_TO_WR. It keeps `rd_ok` low for every other rank until cycle c+BUS_BUSY+RANK_SWITCH, and it records its rank as the last data rank. `rd_ok` for that last rank stays 1.
- R8: `act_ok[r]` is 0 while ACT_LIMIT or more activates (refreshes or accesses) to rank r were launched within the ACT_WINDOW cycles that end with the current one.
- R9: An access reported in a cycle where `ref_fire` is 1 is ignored. Its bank stays free, and it changes no bus or window state.
- R10: When an interval expires with the owed count already at PEND_LIMIT-1 and no firing, the count stays at PEND_LIMIT-1 and `ref_overflow` rises. `ref_overflow` then stays 1 until reset.
- R11: While `ref_enable` is 0, the timer and the owed count hold their values and no refresh fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_enable | input | 1 | Enables the refresh timer, the owed count and refresh issue |
| acc_valid | input | 1 | The access scheduler launched an access this cycle |
| acc_bank | input | BANK_W | Bank of the launched access |
| acc_read | input | 1 | 1 for a read, 0 for a write |
| ref_fire | output | 1 | A refresh issues this cycle to `ref_bank` |
| ref_bank | output | BANK_W | Bank the next refresh targets |
| ref_pending | output | PEND_W | Number of owed refreshes |
| ref_overflow | output | 1 | Sticky: owed refreshes hit the ceiling |
| bank_free | output | NUM_BANKS | Per-bank idle flags |
| bus_free | output | 1 | Plain bus occupancy has ended |
| wr_ok | output | 1 | A write may use the data bus |
| rd_ok | output | NUM_RANKS | Per rank: a read from that rank may use the data bus |
| act_ok | output | NUM_RANKS | Per rank: the activate window has room |

## Verification
The bench builds the block with two ranks of two banks each and a refresh period of 24, which gives a 6-cycle interval. It uses a bank busy time of 5, a bus busy time of 2, a turnaround of 2, a rank switch of 1, and a 10-cycle window that allows 4 activates. With these values, four banks sharing two ranks can fill an activate window, and the pointer wraps many times. A short starvation run also drives the owed count to its ceiling of 9. Random enable and access traffic runs against a cycle model kept in terms of launch times. Directed runs then cover a coincident access, a disabled stretch and overflow.

// File: rtl/refresh_rotator_pkg.sv
package refresh_rotator_pkg;

  // Command that occupies the shared bus in a cycle
  typedef enum logic [1:0] {
    CMD_IDLE    = 2'd0,
    CMD_REFRESH = 2'd1,
    CMD_READ    = 2'd2,
    CMD_WRITE   = 2'd3
  } bus_cmd_e;

  // Index width that never collapses to zero
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rr_interval_timer.sv
module rr_interval_timer
  import refresh_rotator_pkg::*;
#(
  parameter int unsigned INTERVAL   = 195,
  parameter int unsigned PEND_LIMIT = 10,
  localparam int unsigned TMR_W  = idx_width(INTERVAL + 1),
  localparam int unsigned PEND_W = idx_width(PEND_LIMIT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              take_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              ovf_o
);

  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              ovf_q, ovf_d;
  logic              expire;

  always_comb begin
    expire = run_i && (tmr_q == TMR_W'(1));
    tmr_d  = tmr_q;
    pend_d = pend_q;
    ovf_d  = ovf_q;
    if (run_i) begin
      if (expire) tmr_d = TMR_W'(INTERVAL);
      else        tmr_d = tmr_q - TMR_W'(1);
      if (expire && !take_i) begin
        if (pend_q == PEND_W'(PEND_LIMIT - 1)) ovf_d  = 1'b1;
        else                                   pend_d = pend_q + PEND_W'(1);
      end else if (!expire && take_i) begin
        pend_d = pend_q - PEND_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= TMR_W'(1);
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      tmr_q  <= tmr_d;
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  assign pend_o = pend_q;
  assign ovf_o  = ovf_q;

endmodule

// File: rtl/rr_bank_busy.sv
module rr_bank_busy
  import refresh_rotator_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned BUSY_CYCLES = 11,
  localparam int unsigned BANK_W = idx_width(NUM_BANKS),
  localparam int unsigned CNT_W  = idx_width(BUSY_CYCLES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_i,
  input  logic [BANK_W-1:0]    set_bank_i,
  output logic [NUM_BANKS-1:0] free_o
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hit;

    assign hit = set_i && (set_bank_i == BANK_W'(g));

    always_comb begin
      cnt_d = cnt_q;
      if (hit)                cnt_d = CNT_W'(BUSY_CYCLES - 1);
      else if (cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign free_o[g] = (cnt_q == '0);
  end

endmodule

// File: rtl/rr_bus_tracker.sv
module rr_bus_tracker
  import refresh_rotator_pkg::*;
#(
  parameter int unsigned NUM_RANKS   = 2,
  parameter int unsigned BUS_BUSY    = 2,
  parameter int unsigned RD_TO_WR    = 2,
  parameter int unsigned RANK_SWITCH = 1,
  localparam int unsigned RANK_W = idx_width(NUM_RANKS),
  localparam int unsigned CNT_W  = idx_width(BUS_BUSY + RD_TO_WR + RANK_SWITCH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bus_cmd_e             cmd_i,
  input  logic [RANK_W-1:0]    rank_i,
  output logic                 bus_free_o,
  output logic                 wr_ok_o,
  output logic [NUM_RANKS-1:0] rd_ok_o
);

  localparam logic [CNT_W-1:0] LD_PLAIN = CNT_W'(BUS_BUSY - 1);
  localparam logic [CNT_W-1:0] LD_WTURN = CNT_W'(BUS_BUSY + RD_TO_WR - 1);
  localparam logic [CNT_W-1:0] LD_RSW   = CNT_W'(BUS_BUSY + RANK_SWITCH - 1);

  logic [CNT_W-1:0]  base_q, base_d, wturn_q, wturn_d, rsw_q, rsw_d;
  logic [RANK_W-1:0] last_q, last_d;

  always_comb begin
    base_d  = (base_q  != '0) ? base_q  - CNT_W'(1) : base_q;
    wturn_d = (wturn_q != '0) ? wturn_q - CNT_W'(1) : wturn_q;
    rsw_d   = (rsw_q   != '0) ? rsw_q   - CNT_W'(1) : rsw_q;
    last_d  = last_q;
    unique case (cmd_i)
      CMD_REFRESH: begin
        base_d  = LD_PLAIN;
        wturn_d = LD_PLAIN;
        rsw_d   = LD_PLAIN;
      end
      CMD_READ: begin
        base_d  = LD_PLAIN;
        wturn_d = LD_WTURN;
        rsw_d   = LD_RSW;
        last_d  = rank_i;
      end
      CMD_WRITE: begin
        base_d  = LD_PLAIN;
        wturn_d = LD_PLAIN;
        rsw_d   = LD_PLAIN;
        last_d  = rank_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      wturn_q <= '0;
      rsw_q   <= '0;
      last_q  <= '0;
    end else begin
      base_q  <= base_d;
      wturn_q <= wturn_d;
      rsw_q   <= rsw_d;
      last_q  <= last_d;
    end
  end

  assign bus_free_o = (base_q == '0);
  assign wr_ok_o    = (wturn_q == '0);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rd
    assign rd_ok_o[r] = (last_q == RANK_W'(r)) || (rsw_q == '0);
  end

endmodule

// File: rtl/rr_act_window.sv
module rr_act_window
  import refresh_rotator_pkg::*;
#(
  parameter int unsigned NUM_RANKS  = 2,
  parameter int unsigned ACT_WINDOW = 16,
  parameter int unsigned ACT_LIMIT  = 4,
  localparam int unsigned RANK_W = idx_width(NUM_RANKS),
  localparam int unsigned SH_W   = (ACT_WINDOW > 1) ? ACT_WINDOW - 1 : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mark_i,
  input  logic [RANK_W-1:0]    mark_rank_i,
  output logic [NUM_RANKS-1:0] open_o
);

  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_rank
    logic [SH_W-1:0] sh_q, sh_d;
    int unsigned     ones;

    always_comb begin
      sh_d = sh_q >> 1;
      if (mark_i && (mark_rank_i == RANK_W'(g))) sh_d[SH_W-1] = 1'b1;
    end

    always_comb begin
      ones = 0;
      for (int i = 0; i < SH_W; i++) begin
        if (sh_q[i]) ones = ones + 1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign open_o[g] = (ones < ACT_LIMIT);
  end

endmodule

// File: rtl/refresh_rotator.sv
module refresh_rotator
  import refresh_rotator_pkg::*;
#(
  parameter int unsigned NUM_RANKS      = 2,
  parameter int unsigned BANKS_PER_RANK = 4,
  parameter int unsigned REFRESH_PERIOD = 1560,
  parameter int unsigned BANK_BUSY      = 11,
  parameter int unsigned BUS_BUSY       = 2,
  parameter int unsigned RD_TO_WR       = 2,
  parameter int unsigned RANK_SWITCH    = 1,
  parameter int unsigned ACT_WINDOW     = 16,
  parameter int unsigned ACT_LIMIT      = 4,
  parameter int unsigned PEND_LIMIT     = 10,
  localparam int unsigned NUM_BANKS = NUM_RANKS * BANKS_PER_RANK,
  localparam int unsigned BANK_W    = idx_width(NUM_BANKS),
  localparam int unsigned RANK_W    = idx_width(NUM_RANKS),
  localparam int unsigned PEND_W    = idx_width(PEND_LIMIT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_enable,
  input  logic                 acc_valid,
  input  logic [BANK_W-1:0]    acc_bank,
  input  logic                 acc_read,
  output logic                 ref_fire,
  output logic [BANK_W-1:0]    ref_bank,
  output logic [PEND_W-1:0]    ref_pending,
  output logic                 ref_overflow,
  output logic [NUM_BANKS-1:0] bank_free,
  output logic                 bus_free,
  output logic                 wr_ok,
  output logic [NUM_RANKS-1:0] rd_ok,
  output logic [NUM_RANKS-1:0] act_ok
);

  localparam int unsigned INTERVAL = (REFRESH_PERIOD / NUM_BANKS > 0) ? REFRESH_PERIOD / NUM_BANKS : 1;

  logic [BANK_W-1:0] ptr_q, ptr_d;
  logic [RANK_W-1:0] ptr_rank, acc_rank, mark_rank;
  logic              acc_take, busy_set;
  logic [BANK_W-1:0] busy_bank;
  bus_cmd_e          cmd;

  assign ptr_rank = RANK_W'(32'(ptr_q) / BANKS_PER_RANK);
  assign acc_rank = RANK_W'(32'(acc_bank) / BANKS_PER_RANK);

  // Refresh is weighed first; a coincident access report is dropped
  assign ref_fire = ref_enable && (ref_pending != '0) && bank_free[ptr_q]
                  && bus_free && act_ok[ptr_rank];
  assign acc_take = acc_valid && !ref_fire;

  always_comb begin
    if (ref_fire)      cmd = CMD_REFRESH;
    else if (acc_take) cmd = acc_read ? CMD_READ : CMD_WRITE;
    else               cmd = CMD_IDLE;
  end

  assign busy_set  = ref_fire || acc_take;
  assign busy_bank = ref_fire ? ptr_q : acc_bank;
  assign mark_rank = ref_fire ? ptr_rank : acc_rank;

  always_comb begin
    ptr_d = ptr_q;
    if (ref_fire) begin
      if (ptr_q == BANK_W'(NUM_BANKS - 1)) ptr_d = '0;
      else                                 ptr_d = ptr_q + BANK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ref_bank = ptr_q;

  rr_interval_timer #(
    .INTERVAL  (INTERVAL),
    .PEND_LIMIT(PEND_LIMIT)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (ref_enable),
    .take_i(ref_fire),
    .pend_o(ref_pending),
    .ovf_o (ref_overflow)
  );

  rr_bank_busy #(
    .NUM_BANKS  (NUM_BANKS),
    .BUSY_CYCLES(BANK_BUSY)
  ) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (busy_set),
    .set_bank_i(busy_bank),
    .free_o    (bank_free)
  );

  rr_bus_tracker #(
    .NUM_RANKS  (NUM_RANKS),
    .BUS_BUSY   (BUS_BUSY),
    .RD_TO_WR   (RD_TO_WR),
    .RANK_SWITCH(RANK_SWITCH)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (cmd),
    .rank_i    (acc_rank),
    .bus_free_o(bus_free),
    .wr_ok_o   (wr_ok),
    .rd_ok_o   (rd_ok)
  );

  rr_act_window #(
    .NUM_RANKS (NUM_RANKS),
    .ACT_WINDOW(ACT_WINDOW),
    .ACT_LIMIT (ACT_LIMIT)
  ) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .mark_i     (busy_set),
    .mark_rank_i(mark_rank),
    .open_o     (act_ok)
  );

endmodule

// File: rtl/refresh_rotator_chk.sv
module refresh_rotator_chk #(
  parameter int unsigned NUM_BANKS      = 8,
  parameter int unsigned NUM_RANKS      = 2,
  parameter int unsigned BANKS_PER_RANK = 4,
  parameter int unsigned BANK_BUSY      = 11,
  parameter int unsigned BUS_BUSY       = 2,
  parameter int unsigned PEND_LIMIT     = 10,
  parameter int unsigned BANK_W         = 3,
  parameter int unsigned RANK_W         = 1,
  parameter int unsigned PEND_W         = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ref_enable,
  input logic                 ref_fire,
  input logic [BANK_W-1:0]    ref_bank,
  input logic [PEND_W-1:0]    ref_pending,
  input logic                 ref_overflow,
  input logic [NUM_BANKS-1:0] bank_free,
  input logic                 bus_free,
  input logic [NUM_RANKS-1:0] act_ok
);

  logic [RANK_W-1:0] tgt_rank;
  assign tgt_rank = RANK_W'(32'(ref_bank) / BANKS_PER_RANK);

  // R3
  fire_needs_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |-> (ref_pending != '0) && ref_enable && bus_free && bank_free[ref_bank]);

  // R8
  fire_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |-> act_ok[tgt_rank]);

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_fire && ref_bank == BANK_W'(NUM_BANKS - 1)) |=> (ref_bank == '0));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_fire && ref_bank != BANK_W'(NUM_BANKS - 1)) |=> (ref_bank == $past(ref_bank) + BANK_W'(1)));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_fire |=> $stable(ref_bank));

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_overflow |=> ref_overflow);

  // R10
  pend_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pending <= PEND_W'(PEND_LIMIT - 1));

  // R11
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_enable |=> $stable(ref_pending));

  if (BANK_BUSY > 1) begin : g_bank_chk
    // R5
    bank_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_fire |=> !bank_free[$past(ref_bank)]);
  end

  if (BUS_BUSY > 1) begin : g_bus_chk
    // R6
    bus_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_fire |=> !bus_free);
  end

endmodule

bind refresh_rotator refresh_rotator_chk #(
  .NUM_BANKS     (NUM_BANKS),
  .NUM_RANKS     (NUM_RANKS),
  .BANKS_PER_RANK(BANKS_PER_RANK),
  .BANK_BUSY     (BANK_BUSY),
  .BUS_BUSY      (BUS_BUSY),
  .PEND_LIMIT    (PEND_LIMIT),
  .BANK_W        (BANK_W),
  .RANK_W        (RANK_W),
  .PEND_W        (PEND_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_enable  (ref_enable),
  .ref_fire    (ref_fire),
  .ref_bank    (ref_bank),
  .ref_pending (ref_pending),
  .ref_overflow(ref_overflow),
  .bank_free   (bank_free),
  .bus_free    (bus_free),
  .act_ok      (act_ok)
);

// File: tb/sim_refresh_rotator.sv
module sim_refresh_rotator;

  localparam int NR = 2, BPR = 2, NB = 4, PERIOD = 24, BB = 5, BUS = 2;
  localparam int RW = 2, RR = 1, WIN = 10, LIM = 4, PL = 10;
  localparam int IV = PERIOD / NB;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, en, av, ar;
  logic [1:0]    ab;
  logic          fire;
  logic [1:0]    rb;
  logic [3:0]    pendo;
  logic          ovfo;
  logic [NB-1:0] bfree;
  logic          busf, wrok;
  logic [NR-1:0] rdok, actok;

  refresh_rotator #(
    .NUM_RANKS(NR), .BANKS_PER_RANK(BPR), .REFRESH_PERIOD(PERIOD),
    .BANK_BUSY(BB), .BUS_BUSY(BUS), .RD_TO_WR(RW), .RANK_SWITCH(RR),
    .ACT_WINDOW(WIN), .ACT_LIMIT(LIM), .PEND_LIMIT(PL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ref_enable(en), .acc_valid(av), .acc_bank(ab),
    .acc_read(ar), .ref_fire(fire), .ref_bank(rb), .ref_pending(pendo),
    .ref_overflow(ovfo), .bank_free(bfree), .bus_free(busf), .wr_ok(wrok),
    .rd_ok(rdok), .act_ok(actok)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // Reference model kept as launch times
  int cyc, m_pend, m_ptr, m_en_cnt, m_last;
  bit m_ovf;
  int bank_at[NB];
  int basic_at, wr_at, rr_at;
  int act_at[NR][WIN];

  function automatic int faw_cnt(int r);
    int n = 0;
    for (int i = 0; i < WIN; i++)
      if (act_at[r][i] < cyc && cyc - act_at[r][i] < WIN) n++;
    return n;
  endfunction

  function automatic bit m_fire(bit e);
    return e && m_pend > 0 && cyc >= bank_at[m_ptr] && cyc >= basic_at
           && faw_cnt(m_ptr / BPR) < LIM;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic model_reset();
    cyc = 0; m_pend = 0; m_ptr = 0; m_en_cnt = 0; m_last = 0; m_ovf = 0;
    basic_at = 0; wr_at = 0; rr_at = 0;
    for (int b = 0; b < NB; b++) bank_at[b] = 0;
    for (int r = 0; r < NR; r++)
      for (int i = 0; i < WIN; i++) act_at[r][i] = -1000;
  endtask

  task automatic step(bit e, bit v, int b, bit rd);
    bit f, tick;
    int ev;
    en = e; av = v; ab = b[1:0]; ar = rd;
    #1;
    f = m_fire(e);
    chk("R3 ref_fire", int'(fire), int'(f));
    chk("R4 ref_bank", int'(rb), m_ptr);
    chk("R2 ref_pending", int'(pendo), m_pend);
    chk("R10 ref_overflow", int'(ovfo), int'(m_ovf));
    ev = 0;
    for (int k = 0; k < NB; k++) if (cyc >= bank_at[k]) ev |= (1 << k);
    chk("R5 bank_free", int'(bfree), ev);
    chk("R6 bus_free", int'(busf), int'(cyc >= basic_at));
    chk("R7 wr_ok", int'(wrok), int'(cyc >= wr_at));
    ev = 0;
    for (int r = 0; r < NR; r++) if (r == m_last || cyc >= rr_at) ev |= (1 << r);
    chk("R7 rd_ok", int'(rdok), ev);
    ev = 0;
    for (int r = 0; r < NR; r++) if (faw_cnt(r) < LIM) ev |= (1 << r);
    chk("R8 act_ok", int'(actok), ev);
    // advance model by one cycle
    tick = e && (m_en_cnt % IV == 0);
    if (e) begin
      m_en_cnt++;
      if (tick && !f) begin
        if (m_pend == PL - 1) m_ovf = 1;
        else m_pend++;
      end else if (!tick && f) m_pend--;
    end
    if (f) begin
      bank_at[m_ptr] = cyc + BB;
      basic_at = cyc + BUS; wr_at = cyc + BUS; rr_at = cyc + BUS;
      act_at[m_ptr / BPR][cyc % WIN] = cyc;
      m_ptr = (m_ptr == NB - 1) ? 0 : m_ptr + 1;
    end else if (v) begin
      bank_at[b] = cyc + BB;
      basic_at = cyc + BUS;
      wr_at = cyc + BUS + (rd ? RW : 0);
      rr_at = cyc + BUS + (rd ? RR : 0);
      m_last = b / BPR;
      act_at[b / BPR][cyc % WIN] = cyc;
    end
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    int hits, p, fires, ob;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; en = 0; av = 0; ab = 0; ar = 0;
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    // R1: state while reset is held
    chk("R1 pending in reset", int'(pendo), 0);
    chk("R1 pointer in reset", int'(rb), 0);
    chk("R1 overflow in reset", int'(ovfo), 0);
    chk("R1 fire in reset", int'(fire), 0);
    chk("R1 banks free in reset", int'(bfree), (1 << NB) - 1);
    rst_n = 1'b1;

    // Random traffic against the model
    for (int i = 0; i < 3000; i++)
      step(($urandom % 10) != 0, ($urandom % 10) < 4, int'($urandom % NB), $urandom % 2);

    // R9: access coinciding with a refresh is dropped
    hits = 0;
    for (int i = 0; i < 300 && hits == 0; i++) begin
      ob = -1;
      if (m_fire(1))
        for (int k = 0; k < NB; k++)
          if (k != m_ptr && cyc >= bank_at[k] && ob < 0) ob = k;
      if (ob >= 0) begin
        step(1, 1, ob, 1);
        #1;
        chk("R9 dropped access leaves bank free", int'(bfree[ob]), 1);
        hits++;
      end else begin
        step(1, 0, 0, 0);
      end
    end
    chk("R9 coincident case reached", hits, 1);

    // R11: disabled stretch freezes owed count and blocks issue
    p = int'(pendo);
    fires = 0;
    for (int i = 0; i < 40; i++) begin
      step(0, ($urandom % 10) < 3, int'($urandom % NB), $urandom % 2);
      #1;
      if (fire) fires++;
    end
    chk("R11 pending frozen", int'(pendo), p);
    chk("R11 no refresh while disabled", fires, 0);

    // R10: starve the target bank until the owed count hits the ceiling
    for (int i = 0; i < 120; i++) step(1, 1, int'(rb), 0);
    chk("R10 overflow raised", int'(ovfo), 1);
    chk("R10 pending saturates", int'(pendo), PL - 1);
    for (int i = 0; i < 60; i++) step(1, 0, 0, 0);
    chk("R10 overflow sticky", int'(ovfo), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule